// File: doc/BRIEF.md
# Pipelined Radix Partition Tree Sorter

This block sorts a batch of `BATCH` unsigned keys of `KEY_W` bits each. It works as a tree of identical nodes with fanout `FANOUT`. Each node looks at one digit of the key, where a digit is log2(`FANOUT`) bits, and the most significant digit comes first. The node spreads its sub-batch into `FANOUT` child groups by the value of that digit. It then joins the ordered results of its children back into one stream, with the child for digit value zero first. A node at level l covers a nominal sub-problem of `BATCH`/`FANOUT`^l keys. A node whose group holds a single key, or that is past the last digit, passes its keys through unchanged.

The hardware lays the tree out as one pipeline stage per level. Every node of a level is evaluated in the same cycle. The top level's node takes the whole batch, and each deeper level refines the groups left by the level above. A batch enters in parallel with a one-cycle `in_valid` strobe. It leaves in parallel, fully ordered, with a one-cycle `out_done` strobe after a fixed latency that depends only on the number of levels. A new batch may enter on every cycle.

Top module: `fr_sort_tree`

## Requirements
- R1: On a cycle with `out_done` high, the key slots of `out_keys` are in non-decreasing order. Slot i occupies bits [i*KEY_W +: KEY_W], and slot 0 holds the smallest key.
- R2: On a cycle with `out_done` high, `out_keys` holds exactly the multiset of keys that entered with the matching batch, duplicates included.
- R3: A batch captured at a rising edge with `in_valid` high shows up on the outputs after LEVELS rising edges, counting the capture edge, where LEVELS = KEY_W / log2(FANOUT). For that batch `out_done` is high for exactly one cycle.
- R4: Batches may be presented on consecutive cycles. Each one is sorted independently and produces its own `out_done` cycle, in arrival order.
- R5: While `rst_n` is low (synchronous, active low), `out_done` is low and `out_keys` is all zeros. A batch that was in flight when reset was asserted never produces `out_done`.
- R6: On any cycle with `out_done` low, `out_keys` keeps the value it had on the cycle before.
- R7: On a cycle with `in_valid` low, the value on `in_keys` has no effect on `out_done` or `out_keys`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Batch strobe; `in_keys` is captured on this cycle |
| in_keys | input | BATCH*KEY_W | Unsorted batch, slot i at bits [i*KEY_W +: KEY_W] |
| out_done | output | 1 | One-cycle strobe marking a fully ordered batch on `out_keys` |
| out_keys | output | BATCH*KEY_W | Ordered batch, slot 0 smallest |

## Verification
The bench targets batches heavy with duplicates: all keys equal, only two distinct values, and an affine sweep that covers every stride and offset. A node that counts a tied key twice or drops it would leave a slot repeated or zeroed. It sends descending and alternating batches, where a level that examined digits in the wrong order or put the high child first would come out reversed or interleaved. It streams thousands of batches back to back and with random gaps, driving junk keys while the strobe is low. An off-by-one in the pipeline would move `out_done` by a cycle, and loading on an idle cycle would disturb the held output. A reset in the middle of a stream checks that no stale `out_done` escapes.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int unsigned FR_KEY_W_DEF  = 3;
    localparam int unsigned FR_BATCH_DEF  = 8;
    localparam int unsigned FR_FANOUT_DEF = 2;

    // number of tree levels: one digit of log2(fanout) bits per level
    function automatic int unsigned fr_levels(input int unsigned key_w,
                                              input int unsigned fanout);
        return key_w / $clog2(fanout);
    endfunction

endpackage

// File: rtl/fr_route.sv
// Distribution half of every node on one level: computes the slot each key
// moves to. Keys are ranked by (prefix above the digit, digit, input index),
// which groups by the parent node, orders children by digit value and keeps
// equal-digit keys in their arrival order.
module fr_route #(
    parameter int unsigned W   = 3,
    parameter int unsigned NB  = 8,
    parameter int unsigned B   = 2,
    parameter int unsigned LVL = 0
) (
    input  logic [NB-1:0][W-1:0]          keys_i,
    output logic [NB-1:0][$clog2(NB)-1:0] dest_o
);
    localparam int unsigned DB   = $clog2(B);
    localparam int unsigned HI   = W - LVL * DB;
    localparam int unsigned IDXW = $clog2(NB);

    function automatic logic [W:0] pre_of(input logic [W-1:0] k);
        return {1'b0, k} >> HI;
    endfunction

    function automatic logic [W:0] dig_of(input logic [W-1:0] k);
        return ({1'b0, k} >> (HI - DB)) & (W+1)'(B - 1);
    endfunction

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            int unsigned cnt;
            cnt = 0;
            for (int j = 0; j < NB; j++) begin
                if (pre_of(keys_i[j]) < pre_of(keys_i[i])) begin
                    cnt = cnt + 1;
                end else if (pre_of(keys_i[j]) == pre_of(keys_i[i])) begin
                    if (dig_of(keys_i[j]) < dig_of(keys_i[i])) begin
                        cnt = cnt + 1;
                    end else if (dig_of(keys_i[j]) == dig_of(keys_i[i]) && j < i) begin
                        cnt = cnt + 1;
                    end
                end
            end
            dest_o[i] = IDXW'(cnt);
        end
    end

endmodule

// File: rtl/fr_gather.sv
// Aggregation half of every node on one level: each output slot collects
// the single key routed to it, so child groups join in digit order.
module fr_gather #(
    parameter int unsigned W  = 3,
    parameter int unsigned NB = 8
) (
    input  logic [NB-1:0][W-1:0]          keys_i,
    input  logic [NB-1:0][$clog2(NB)-1:0] dest_i,
    output logic [NB-1:0][W-1:0]          keys_o
);
    localparam int unsigned IDXW = $clog2(NB);

    always_comb begin
        keys_o = '0;
        for (int o = 0; o < NB; o++) begin
            for (int i = 0; i < NB; i++) begin
                if (dest_i[i] == IDXW'(o)) begin
                    keys_o[o] = keys_o[o] | keys_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/fr_stage.sv
// One tree level: distribution, aggregation and the level's pipeline register.
module fr_stage #(
    parameter int unsigned W   = 3,
    parameter int unsigned NB  = 8,
    parameter int unsigned B   = 2,
    parameter int unsigned LVL = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic [NB-1:0][W-1:0] keys_i,
    output logic                 vld_o,
    output logic [NB-1:0][W-1:0] keys_o
);
    localparam int unsigned IDXW = $clog2(NB);

    typedef struct packed {
        logic                 vld;
        logic [NB-1:0][W-1:0] keys;
    } stage_t;

    stage_t                  st_d, st_q;
    logic [NB-1:0][IDXW-1:0] dest;
    logic [NB-1:0][W-1:0]    merged;

    fr_route #(.W(W), .NB(NB), .B(B), .LVL(LVL)) u_route (
        .keys_i (keys_i),
        .dest_o (dest)
    );

    fr_gather #(.W(W), .NB(NB)) u_gather (
        .keys_i (keys_i),
        .dest_i (dest),
        .keys_o (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.keys = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld;
    assign keys_o = st_q.keys;

endmodule

// File: rtl/fr_sort_tree.sv
module fr_sort_tree #(
    parameter int unsigned KEY_W  = fr_pkg::FR_KEY_W_DEF,
    parameter int unsigned BATCH  = fr_pkg::FR_BATCH_DEF,
    parameter int unsigned FANOUT = fr_pkg::FR_FANOUT_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [BATCH*KEY_W-1:0]   in_keys,
    output logic                     out_done,
    output logic [BATCH*KEY_W-1:0]   out_keys
);
    localparam int unsigned LEVELS = fr_pkg::fr_levels(KEY_W, FANOUT);

    logic [LEVELS:0]                 vld_ch;
    logic [BATCH-1:0][KEY_W-1:0]     key_ch [LEVELS+1];

    assign vld_ch[0] = in_valid;
    assign key_ch[0] = in_keys;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        fr_stage #(.W(KEY_W), .NB(BATCH), .B(FANOUT), .LVL(l)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (vld_ch[l]),
            .keys_i (key_ch[l]),
            .vld_o  (vld_ch[l+1]),
            .keys_o (key_ch[l+1])
        );
    end

    assign out_done = vld_ch[LEVELS];
    assign out_keys = key_ch[LEVELS];

endmodule

// File: rtl/fr_sort_tree_chk.sv
module fr_sort_tree_chk #(
    parameter int unsigned KEY_W  = fr_pkg::FR_KEY_W_DEF,
    parameter int unsigned BATCH  = fr_pkg::FR_BATCH_DEF,
    parameter int unsigned FANOUT = fr_pkg::FR_FANOUT_DEF
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   out_done,
    input logic [BATCH*KEY_W-1:0] out_keys
);
    localparam int unsigned LEVELS = fr_pkg::fr_levels(KEY_W, FANOUT);
    localparam int unsigned CW     = $clog2(LEVELS + 2) + 1;

    logic [CW-1:0] inflight_q;
    logic [CW-1:0] idle_q;

    function automatic bit ordered(input logic [BATCH*KEY_W-1:0] v);
        bit ok;
        ok = 1'b1;
        for (int i = 1; i < BATCH; i++) begin
            if (v[i*KEY_W +: KEY_W] < v[(i-1)*KEY_W +: KEY_W]) ok = 1'b0;
        end
        return ok;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= '0;
            idle_q     <= CW'(LEVELS);
        end else begin
            inflight_q <= inflight_q + CW'(in_valid) - CW'(out_done);
            if (in_valid)                 idle_q <= '0;
            else if (idle_q != CW'(LEVELS)) idle_q <= idle_q + 1'b1;
        end
    end

    AST_OUT_ORDERED: assert property (@(posedge clk) disable iff (!rst_n) out_done |-> ordered(out_keys)); // R1
    AST_NO_LATE_DONE: assert property (@(posedge clk) disable iff (!rst_n) (idle_q == CW'(LEVELS)) |-> !out_done); // R3
    AST_DONE_HAS_BATCH: assert property (@(posedge clk) disable iff (!rst_n) out_done |-> (inflight_q != '0)); // R4
    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) inflight_q <= CW'(LEVELS)); // R4
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_done); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !out_done |-> $stable(out_keys)); // R6

endmodule

bind fr_sort_tree fr_sort_tree_chk #(.KEY_W(KEY_W), .BATCH(BATCH), .FANOUT(FANOUT)) u_chk (.*);

// File: tb/sim_fr_sort_tree.sv
`timescale 1ns/1ps
module sim_fr_sort_tree;
    localparam int W  = 3;
    localparam int NB = 8;
    localparam int B  = 2;
    localparam int L  = W / $clog2(B);
    localparam int FW = NB * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [FW-1:0] in_keys = '0;
    logic          out_done;
    logic [FW-1:0] out_keys;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [FW:0]   pend [$];
    logic [FW-1:0] last_sorted = '0;
    bit            have_last = 1'b0;
    logic [31:0]   seed = 32'h1357_9bdf;

    always #2.5 clk = ~clk;

    fr_sort_tree #(.KEY_W(W), .BATCH(NB), .FANOUT(B)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_keys  (in_keys),
        .out_done (out_done),
        .out_keys (out_keys)
    );

    // counting sort from the requirement: values ascending, duplicates kept
    function automatic logic [FW-1:0] ref_sort(input logic [FW-1:0] k);
        logic [FW-1:0] r;
        int pos;
        r = '0;
        pos = 0;
        for (int v = 0; v < (1 << W); v++) begin
            for (int i = 0; i < NB; i++) begin
                if (int'(k[i*W +: W]) == v) begin
                    r[pos*W +: W] = W'(v);
                    pos++;
                end
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [FW-1:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[30:7];
    endfunction

    // one cycle: check what the batch driven L cycles ago produced, then drive
    task automatic step(input bit v, input logic [FW-1:0] k);
        logic [FW:0] item;
        @(negedge clk);
        if (pend.size() == L) begin
            item = pend.pop_front();
            check("R3 done timing", FW'(out_done), FW'(item[FW]));
            if (item[FW]) begin
                check("R1 R2 R4 sorted batch", out_keys, ref_sort(item[FW-1:0]));
                last_sorted = ref_sort(item[FW-1:0]);
                have_last = 1'b1;
            end else if (have_last) begin
                check("R6 R7 output held", out_keys, last_sorted);
            end
        end else begin
            check("R3 no early done", FW'(out_done), '0);
        end
        in_valid = v;
        in_keys  = k;
        pend.push_back({v, k});
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 reset done low", FW'(out_done), '0);
        check("R5 reset keys zero", out_keys, '0);
        pend.delete();
        have_last = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic flush();
        for (int i = 0; i < L + 2; i++) step(1'b0, next_rand());
    endtask

    function automatic logic [FW-1:0] fill(input int a, input int b);
        logic [FW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*W +: W] = W'(a * i + b);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // directed: all equal, ascending, descending, two values interleaved
        step(1'b1, '0);
        step(1'b0, '1);
        step(1'b1, '1);
        step(1'b0, next_rand());
        step(1'b1, fill(1, 0));
        step(1'b1, fill(7, 7));
        step(1'b1, fill(0, 5));
        step(1'b1, {NB/2{{W{1'b1}}, {W{1'b0}}}});
        flush();
        // affine sweep over every stride and offset, back to back
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                step(1'b1, fill(a, b));
        flush();
        // random batches every cycle
        for (int n = 0; n < 3000; n++) step(1'b1, next_rand());
        // random batches with idle gaps carrying junk keys
        for (int n = 0; n < 3000; n++) step(seed[3], next_rand());
        flush();
        // reset while batches are in flight: none may complete afterwards
        for (int n = 0; n < L; n++) step(1'b1, next_rand());
        do_reset();
        for (int n = 0; n < L + 2; n++) begin
            @(negedge clk);
            check("R5 no stale done", FW'(out_done), '0);
        end
        step(1'b1, fill(3, 1));
        flush();
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule